// File: doc/BRIEF.md
# Two-Threshold Windowed Spike Detector

This block finds action-potential spikes in a stream of 16-bit signed samples by demanding two pieces of evidence in order. A rising crossing of a positive threshold on the raw samples opens a timing window of a programmable number of sample periods. A separate copy of the samples passes through a first-order low-pass filter, and a falling crossing of a negative threshold by that filtered value while the window is open declares a spike.

Both the window and the spike flag are exported, so downstream feature extraction can gate its peak, trough and width measurement on them. Thresholds, the filter coefficient and the window length come from configuration registers outside the block. The negative threshold can either be taken from its register or derived as 0.6 of the positive threshold.

Top module: `spike_win_det`

## Requirements
- R1: While rst_ni is low, window_o and spike_o are 0, and the filter state, the raw previous sample and the window counter are cleared to 0. This holds also when reset is asserted in the middle of an open window.
- R2: A valid sample x with previous valid raw sample p < pos_thr_i and x >= pos_thr_i (signed, equality counts) opens the window if it is closed and win_len_i is non-zero. window_o is high from the clock edge that accepts that sample.
- R3: The window covers the win_len_i valid samples that follow the opening sample. It closes, together with spike_o, at the edge that accepts the next valid sample after those.
- R4: Positive crossings that arrive while the window is open neither restart it nor extend it. The sample that closes the window cannot reopen it.
- R5: On each valid sample the filter computes y' = y + ((x - y) >>> lpf_shift_i) with floor (arithmetic) shift. It starts from y = 0 after reset.
- R6: A falling crossing on the filtered path is y > N and y' <= N (signed, equality counts). N is the active negative threshold.
- R7: spike_o is set only by a falling crossing on a valid sample that lies inside the window, as defined in R3. A crossing while the window is closed, on the opening sample, or on the closing sample is ignored.
- R8: Once set, spike_o stays high until the window closes, and both outputs fall on the same edge.
- R9: With win_len_i = 0 the window never opens and no spike is reported.
- R10: With neg_auto_i = 1, N = -((pos_thr_i * 19661) >>> 15), which is 0.6 of the positive threshold, and neg_thr_i is ignored. With neg_auto_i = 0, N = neg_thr_i.
- R11: Cycles with sample_valid_i low change no state, whatever sample_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Signed input sample |
| sample_valid_i | input | 1 | One-cycle strobe marking a new sample |
| pos_thr_i | input | 16 | Signed positive threshold for the raw path |
| neg_thr_i | input | 16 | Signed negative threshold for the filtered path |
| neg_auto_i | input | 1 | 1: derive negative threshold as 0.6 of positive |
| lpf_shift_i | input | 4 | Filter coefficient as a right shift |
| win_len_i | input | 16 | Window length in sample periods; 0 disables |
| window_o | output | 1 | Window open |
| spike_o | output | 1 | Spike detected within the current window |

## Verification
A wrong filter state shows up only as a spike that appears one or more samples early or late, or not at all. The bench therefore drives slow, multi-sample troughs under several shift values and compares both outputs against an independent model on every clock, so a drift is caught on the first edge where the detection lands in a different cycle. A counter error shows up as a window edge that is off by one sample at the close. The bench exercises this with troughs placed on the last sample inside the window and on the closing sample. A stale previous-sample register shows up as a window that opens without a true transition. Repeated and equal-valued peaks catch that on the first affected sample.

// File: rtl/spike_det_pkg.sv
package spike_det_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int LEN_W     = 16;
  localparam int SHIFT_W   = 4;
  localparam int RATIO_NUM = 19661;  // 0.6 * 2^15
  localparam int RATIO_SH  = 15;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  // negative threshold derived from the positive one
  function automatic sample_t derive_neg(input sample_t pos);
    logic signed [31:0] prod;
    logic signed [31:0] neg;
    prod = 32'(pos) * 32'(RATIO_NUM);
    neg  = -(prod >>> RATIO_SH);
    return sample_t'(neg);
  endfunction
endpackage

// File: rtl/lpf_iir.sv
module lpf_iir #(
  parameter int W  = 16,
  parameter int SW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] x_i,
  input  logic [SW-1:0]       shift_i,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] y_next_o
);
  logic signed [W-1:0] y_q;
  logic signed [W:0]   diff, step, sum;

  always_comb begin
    diff     = {x_i[W-1], x_i} - {y_q[W-1], y_q};
    step     = diff >>> shift_i;
    sum      = {y_q[W-1], y_q} + step;
    y_next_o = sum[W-1:0];  // lies between y and x, always fits
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      y_q <= '0;
    else if (valid_i) y_q <= y_next_o;
  end

  assign y_o = y_q;

  // R11
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_q));
  // R5
  filt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((y_q >= $past(y_q) && y_q <= $past(x_i)) ||
                 (y_q <= $past(y_q) && y_q >= $past(x_i))));
endmodule

// File: rtl/xing_det.sv
module xing_det #(
  parameter int W      = 16,
  parameter bit RISING = 1'b1
) (
  input  logic signed [W-1:0] prev_i,
  input  logic signed [W-1:0] cur_i,
  input  logic signed [W-1:0] thr_i,
  output logic                hit_o
);
  generate
    if (RISING) begin : g_rise
      assign hit_o = (prev_i < thr_i) && (cur_i >= thr_i);
    end else begin : g_fall
      assign hit_o = (prev_i > thr_i) && (cur_i <= thr_i);
    end
  endgenerate
endmodule

// File: rtl/win_timer.sv
module win_timer #(
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          open_i,
  input  logic          trough_i,
  input  logic [LW-1:0] len_i,
  output logic          window_o,
  output logic          spike_o
);
  logic          win_q, spk_q;
  logic [LW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q >= len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      spk_q <= 1'b0;
      cnt_q <= '0;
    end else if (valid_i) begin
      if (win_q) begin
        if (at_end) begin
          win_q <= 1'b0;
          spk_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (trough_i) spk_q <= 1'b1;
        end
      end else if (open_i && (len_i != '0)) begin
        win_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  assign window_o = win_q;
  assign spike_o  = spk_q;

  // R3
  win_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_q) |-> $past(valid_i && cnt_q >= len_i));
  // R9
  win_len_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_q) |-> $past(len_i != '0));
  // R4
  win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q && valid_i && !at_end) |=> (win_q && cnt_q == $past(cnt_q) + 1'b1));
  // R8
  spk_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spk_q) |-> $fell(win_q));
  // R7
  spk_in_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spk_q |-> win_q);
  // R7
  spk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spk_q) |-> $past(trough_i && valid_i && win_q));
endmodule

// File: rtl/spike_win_det.sv
module spike_win_det
  import spike_det_pkg::*;
#(
  parameter int SW_W = SHIFT_W,
  parameter int LN_W = LEN_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [15:0]     sample_i,
  input  logic            sample_valid_i,
  input  logic [15:0]     pos_thr_i,
  input  logic [15:0]     neg_thr_i,
  input  logic            neg_auto_i,
  input  logic [SW_W-1:0] lpf_shift_i,
  input  logic [LN_W-1:0] win_len_i,
  output logic            window_o,
  output logic            spike_o
);
  sample_t x, pos_thr, neg_thr, raw_prev_q;
  sample_t filt_q, filt_next;
  logic    pos_hit, neg_hit;

  assign x       = sample_t'(sample_i);
  assign pos_thr = sample_t'(pos_thr_i);
  assign neg_thr = neg_auto_i ? derive_neg(pos_thr) : sample_t'(neg_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             raw_prev_q <= '0;
    else if (sample_valid_i) raw_prev_q <= x;
  end

  xing_det #(.W(SAMPLE_W), .RISING(1'b1)) u_pos_x (
    .prev_i(raw_prev_q), .cur_i(x), .thr_i(pos_thr), .hit_o(pos_hit)
  );

  lpf_iir #(.W(SAMPLE_W), .SW(SW_W)) u_lpf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .x_i     (x),
    .shift_i (lpf_shift_i),
    .y_o     (filt_q),
    .y_next_o(filt_next)
  );

  xing_det #(.W(SAMPLE_W), .RISING(1'b0)) u_neg_x (
    .prev_i(filt_q), .cur_i(filt_next), .thr_i(neg_thr), .hit_o(neg_hit)
  );

  win_timer #(.LW(LN_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .open_i  (pos_hit),
    .trough_i(neg_hit),
    .len_i   (win_len_i),
    .window_o(window_o),
    .spike_o (spike_o)
  );

  // R2
  win_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(window_o) |-> $past(sample_valid_i && pos_hit));
  // R11
  raw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> ($stable(raw_prev_q) && $stable(window_o) && $stable(spike_o)));
endmodule

// File: tb/spike_win_det_tb.sv
`timescale 1ns/1ps
module spike_win_det_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] sample = '0;
  logic        valid = 1'b0;
  logic [15:0] pos_thr = 16'd1000;
  logic [15:0] neg_thr = 16'hFDA8;  // -600
  logic        neg_auto = 1'b0;
  logic [3:0]  shift = 4'd0;
  logic [15:0] win_len = 16'd8;
  logic        window_w, spike_w;

  int    n_vec = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  spike_win_det u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample), .sample_valid_i(valid),
    .pos_thr_i(pos_thr), .neg_thr_i(neg_thr), .neg_auto_i(neg_auto),
    .lpf_shift_i(shift), .win_len_i(win_len), .window_o(window_w), .spike_o(spike_w)
  );

  // behavioural reference
  int m_prev, m_y, m_cnt;
  bit m_win, m_spk;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prev = 0; m_y = 0; m_cnt = 0; m_win = 0; m_spk = 0;
    end else if (valid) begin
      int xs, p, n, yn;
      bit px, nx;
      xs = int'($signed(sample));
      p  = int'($signed(pos_thr));
      n  = neg_auto ? -((p * 19661) >>> 15) : int'($signed(neg_thr));
      yn = m_y + ((xs - m_y) >>> int'(shift));
      px = (m_prev < p) && (xs >= p);
      nx = (m_y > n) && (yn <= n);
      if (m_win) begin
        if (m_cnt >= int'(win_len)) begin m_win = 0; m_spk = 0; m_cnt = 0; end
        else begin m_cnt++; if (nx) m_spk = 1; end
      end else if (px && win_len != 0) begin
        m_win = 1; m_cnt = 0;
      end
      m_prev = xs; m_y = yn;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (window_w !== m_win || spike_w !== m_spk) begin
        n_fail++;
        $display("FAIL %s t=%0t window_o=%0b exp=%0b spike_o=%0b exp=%0b",
                 cur_req, $time, window_w, m_win, spike_w, m_spk);
      end
    end
  end

  task automatic send(input int v);
    @(posedge clk); #1;
    sample = 16'(v); valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      valid = 1'b0; sample = 16'(i * 7919 - 20000);
    end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) send(0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    n_vec++;
    if (window_w !== 1'b0 || spike_w !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 window_o=%0b spike_o=%0b exp=0 0", window_w, spike_w);
    end
    rst_ni = 1'b1;
    quiet(3);

    // R2 R6 R7: peak opens window, filtered trough confirms
    cur_req = "R2 R6 R7";
    send(1200); send(500); send(-100); send(-700); send(-200);
    quiet(10);

    // R2 equality on both thresholds
    cur_req = "R2 R6";
    send(1000); send(0); send(-600); quiet(10);

    // R5: slow filter, sustained trough
    cur_req = "R5";
    shift = 4'd2; win_len = 16'd12;
    send(1500); for (int i = 0; i < 10; i++) send(-2000);
    quiet(30);
    shift = 4'd4;
    send(1500); for (int i = 0; i < 14; i++) send(-3000);
    quiet(60);
    shift = 4'd0;

    // R7 trough without peak is ignored; peak without trough gives no spike
    cur_req = "R7";
    win_len = 16'd6;
    send(-1000); send(0); send(200); quiet(2);
    send(1500); send(1500); quiet(8);

    // R4 repeated peaks do not extend
    cur_req = "R4";
    send(1500); send(0); send(1500); send(0); send(1500); send(0); send(1500);
    quiet(6);

    // R3 trough on last in-window sample vs on closing sample
    cur_req = "R3";
    win_len = 16'd3;
    send(1500); send(0); send(0); send(-800); send(0); quiet(3);
    send(1500); send(0); send(0); send(0); send(-800); quiet(3);
    win_len = 16'd1;
    send(1500); send(-800); send(0); quiet(3);
    send(1500); send(0); send(-800); quiet(3);

    // R9 zero length disables
    cur_req = "R9";
    win_len = 16'd0;
    send(1500); send(-900); send(0); quiet(4);
    win_len = 16'd5;

    // R10 derived threshold; neg_thr_i ignored
    cur_req = "R10";
    neg_auto = 1'b1; neg_thr = 16'hEC78;  // -5000, must be ignored
    send(1000); send(-599); send(0); quiet(6);
    send(1000); send(-600); send(0); quiet(6);
    pos_thr = 16'd20000;
    send(20000); send(-11999); send(-12000); quiet(6);
    neg_auto = 1'b0; pos_thr = 16'd1000; neg_thr = 16'hFDA8;

    // R11 invalid cycles carry no state
    cur_req = "R11";
    send(1500); idle(4); send(0); idle(3); send(-700); idle(5); send(0);
    quiet(6);
    idle(3); send(-100); idle(2); send(300); quiet(4);

    // R1 reset in the middle of an open window
    cur_req = "R1";
    send(1500); send(-900); send(0);
    @(posedge clk); #1; rst_ni = 1'b0; valid = 1'b0;
    @(negedge clk);
    n_vec++;
    if (window_w !== 1'b0 || spike_w !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 mid-window window_o=%0b spike_o=%0b exp=0 0", window_w, spike_w);
    end
    @(posedge clk); #1; rst_ni = 1'b1;
    send(0); send(1200); send(-800); quiet(8);

    @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
    end
  end
endmodule